// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the register file for one DMA channel of an Ethernet MAC. Software reaches it through a plain 32-bit word-addressed write port with a combinational read-back. It holds the channel's command bits: a software reset and a transmit-FIFO flush, which both clear themselves, and run bits for the transmit and receive engines. It also turns writes to two poll-demand words into one-cycle wake-up pulses.

The status word collects event pulses from the DMA engines into write-one-to-clear bits. Each event belongs to a normal group or an abnormal group, and each group has a summary bit. The live 3-bit process-state codes of the two engines appear in the same word. A single interrupt line is raised from the summaries and their enables. The engines themselves sit outside the block and reach it only through stub ports.

Word map (word index on `addr`): 0 bus mode, 1 transmit poll, 2 receive poll, 3 status, 4 operation, 5 interrupt enable. Any other index reads 0 and ignores writes.

Top module: `dma_chan_csr`

## Requirements
- R1: After `rst_n` is released, every word reads 0 and `tx_run_o`, `rx_run_o`, `tx_flush_o`, `soft_reset_o`, `tx_poll_o`, `rx_poll_o` and `irq_o` are low.
- R2: Writing 1 to bit 0 of word 0 starts a software reset. Bit 0 and `soft_reset_o` read 1 for exactly RST_CYCLES cycles after the write edge and then drop. The reset clears the operation word, the interrupt-enable word and all status event and summary bits.
- R3: While the software reset is active, writes to any word and event pulses have no effect.
- R4: Bits 0 (transmit run) and 1 (receive run) of word 4 are plain read/write bits. They drive `tx_run_o` and `rx_run_o`.
- R5: Writing 1 to bit 2 of word 4 starts a transmit-FIFO flush. Bit 2 and `tx_flush_o` read 1 for exactly FLUSH_CYCLES cycles after the write and then drop. Writing 0 to bit 2 during the flush does not cut it short.
- R6: A write of any value to word 1 (or word 2) makes `tx_poll_o` (or `rx_poll_o`) high for one cycle, in the cycle after the write edge. The other pulse stays low.
- R7: Status bits 11:0 capture event pulses `evt_i[11:0]` and are cleared by writing 1. Writing 0 leaves them unchanged. An event that arrives in the same cycle as its clear leaves the bit set. The normal events are bits 0 (receive done), 1 (transmit done) and 2 (early receive). The abnormal events are bits 3 to 11 (transmit underflow, jabber, receive overflow, receive buffer unavailable, receive stopped, receive watchdog, early transmit, transmit stopped, fatal bus error).
- R8: Status bit 12 (normal summary) and bit 13 (abnormal summary) are set while some status event of their group is set with its enable bit (same position in word 5) set. A summary drops when those bits are cleared. Writing 1 to a summary clears it until a new enabled event of its group arrives.
- R9: `irq_o` is high when status bit 12 and enable bit 12 are both set, or when status bit 13 and enable bit 13 are both set.
- R10: Status bits 22:20 show `tx_state_i` and bits 19:17 show `rx_state_i` live. Bits 16:14 and 31:23 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W | Word index |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data of the addressed word |
| evt_i | input | 12 | Single-cycle event pulses from the engines |
| tx_state_i | input | 3 | Transmit process-state code |
| rx_state_i | input | 3 | Receive process-state code |
| tx_run_o | output | 1 | Transmit engine run |
| rx_run_o | output | 1 | Receive engine run |
| tx_flush_o | output | 1 | Transmit-FIFO flush in progress |
| soft_reset_o | output | 1 | Software reset in progress |
| tx_poll_o | output | 1 | Transmit poll-demand pulse |
| rx_poll_o | output | 1 | Receive poll-demand pulse |
| irq_o | output | 1 | Channel interrupt |

## Verification
A wrong event or summary register shows up on the next read of word 3 and on `irq_o`, one edge after the pulse or clear. The checks therefore read back right after each stimulus. A self-clearing counter that is off by one changes how many cycles software polls before the command bit drops. The bench counts those cycles exactly, for both reset and flush. A software reset that leaks writes or events leaves non-zero words behind once it ends, so every word is re-read after the reset completes.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
    localparam int DW      = 32;
    localparam int NUM_EVT = 12;

    localparam int W_BUS  = 0;
    localparam int W_TXP  = 1;
    localparam int W_RXP  = 2;
    localparam int W_STAT = 3;
    localparam int W_OP   = 4;
    localparam int W_IEN  = 5;

    localparam int OP_TXRUN = 0;
    localparam int OP_RXRUN = 1;
    localparam int OP_FLUSH = 2;

    localparam int S_NSUM  = 12;
    localparam int S_ASUM  = 13;
    localparam int S_RXST  = 17;
    localparam int S_TXST  = 20;
    localparam int IEN_W   = NUM_EVT + 2;

    localparam logic [NUM_EVT-1:0] NORM_MASK = 12'h007;
    localparam logic [NUM_EVT-1:0] ABN_MASK  = 12'hFF8;
endpackage

// File: rtl/dma_csr_sclr.sv
module dma_csr_sclr #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic clr_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d = '0;
        end else if (s_q.busy) begin
            if (s_q.cnt == '0) s_d.busy = 1'b0;
            else               s_d.cnt  = s_q.cnt - 1'b1;
        end else if (start_i) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CW'(CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o = s_q.busy;

    // R2 / R5: the command bit only drops once the full count has elapsed
    p_selfclear_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.busy) |-> ($past(s_q.cnt) == '0 || $past(clr_i)));
    // R5: nothing but the count or a clear ends the busy window
    p_selfclear_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != '0 && !clr_i) |=> s_q.busy);
endmodule

// File: rtl/dma_csr_cmd.sv
module dma_csr_cmd
    import dma_csr_pkg::*;
#(
    parameter int FLUSH_CYCLES = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       wr_op_i,
    input  logic       wr_txp_i,
    input  logic       wr_rxp_i,
    input  logic [2:0] op_wdata_i,
    output logic       tx_run_o,
    output logic       rx_run_o,
    output logic       flush_o,
    output logic       tx_poll_o,
    output logic       rx_poll_o
);
    typedef struct packed {
        logic tx_run;
        logic rx_run;
        logic tx_poll;
        logic rx_poll;
    } cmd_t;

    cmd_t c_d, c_q;
    logic flush_start;

    always_comb begin
        c_d         = c_q;
        c_d.tx_poll = wr_txp_i;
        c_d.rx_poll = wr_rxp_i;
        if (clr_i) begin
            c_d = '0;
        end else if (wr_op_i) begin
            c_d.tx_run = op_wdata_i[OP_TXRUN];
            c_d.rx_run = op_wdata_i[OP_RXRUN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign flush_start = wr_op_i && op_wdata_i[OP_FLUSH];

    dma_csr_sclr #(.CYCLES(FLUSH_CYCLES)) u_flush (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (flush_start),
        .clr_i   (clr_i),
        .busy_o  (flush_o)
    );

    assign tx_run_o  = c_q.tx_run;
    assign rx_run_o  = c_q.rx_run;
    assign tx_poll_o = c_q.tx_poll;
    assign rx_poll_o = c_q.rx_poll;

    // R4: a run bit changes only through an operation write or a reset clear
    p_run_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_op_i && !clr_i) |=> $stable(tx_run_o) && $stable(rx_run_o));
endmodule

// File: rtl/dma_csr_status.sv
module dma_csr_status
    import dma_csr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               w1c_i,
    input  logic               wr_ien_i,
    input  logic [IEN_W-1:0]   wdata_i,
    output logic [NUM_EVT-1:0] ev_o,
    output logic               nsum_o,
    output logic               asum_o,
    output logic [IEN_W-1:0]   ien_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [NUM_EVT-1:0] ev;
        logic [IEN_W-1:0]   ien;
        logic               nsum;
        logic               asum;
        logic               ngrp;
        logic               agrp;
    } stat_t;

    stat_t s_d, s_q;
    logic [NUM_EVT-1:0] clr_mask, en_ev, new_ev;

    always_comb begin
        s_d      = s_q;
        clr_mask = w1c_i ? wdata_i[NUM_EVT-1:0] : '0;
        if (wr_ien_i) s_d.ien = wdata_i;
        s_d.ev   = (s_q.ev & ~clr_mask) | evt_i;
        en_ev    = s_d.ev & s_d.ien[NUM_EVT-1:0];
        new_ev   = evt_i & s_d.ien[NUM_EVT-1:0];
        s_d.ngrp = |(en_ev & NORM_MASK);
        s_d.agrp = |(en_ev & ABN_MASK);
        s_d.nsum = s_d.ngrp && (|(new_ev & NORM_MASK) || !s_q.ngrp
                   || (s_q.nsum && !(w1c_i && wdata_i[S_NSUM])));
        s_d.asum = s_d.agrp && (|(new_ev & ABN_MASK) || !s_q.agrp
                   || (s_q.asum && !(w1c_i && wdata_i[S_ASUM])));
        if (clr_i) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ev_o   = s_q.ev;
    assign nsum_o = s_q.nsum;
    assign asum_o = s_q.asum;
    assign ien_o  = s_q.ien;
    assign irq_o  = (s_q.nsum && s_q.ien[S_NSUM]) || (s_q.asum && s_q.ien[S_ASUM]);

    // R7: an event pulse is never lost, even against a same-cycle clear
    p_evt_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((ev_o & $past(evt_i)) == $past(evt_i)));
    // R8: an abnormal summary is always backed by an enabled abnormal event
    p_asum_backed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        asum_o |-> |(ev_o & ien_o[NUM_EVT-1:0] & ABN_MASK));
    // R9: the interrupt needs at least one set and enabled event
    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> |(ev_o & ien_o[NUM_EVT-1:0]));
    // R2: after a reset clear, events and enables are empty
    p_clear_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> (ev_o == '0 && ien_o == '0 && !nsum_o && !asum_o));
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
    import dma_csr_pkg::*;
#(
    parameter int ADDR_W       = 3,
    parameter int RST_CYCLES   = 8,
    parameter int FLUSH_CYCLES = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DW-1:0]      wr_data,
    output logic [DW-1:0]      rd_data,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [2:0]         tx_state_i,
    input  logic [2:0]         rx_state_i,
    output logic               tx_run_o,
    output logic               rx_run_o,
    output logic               tx_flush_o,
    output logic               soft_reset_o,
    output logic               tx_poll_o,
    output logic               rx_poll_o,
    output logic               irq_o
);
    logic               we, rst_start, sw_clr;
    logic [NUM_EVT-1:0] ev;
    logic [IEN_W-1:0]   ien;
    logic               nsum, asum;
    logic               unused_wbits;

    assign we        = wr_en && !soft_reset_o;
    assign rst_start = we && (addr == ADDR_W'(W_BUS)) && wr_data[0];
    assign sw_clr    = rst_start || soft_reset_o;
    assign unused_wbits = ^wr_data[DW-1:IEN_W];

    dma_csr_sclr #(.CYCLES(RST_CYCLES)) u_swrst (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (rst_start),
        .clr_i   (1'b0),
        .busy_o  (soft_reset_o)
    );

    dma_csr_cmd #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (sw_clr),
        .wr_op_i    (we && addr == ADDR_W'(W_OP)),
        .wr_txp_i   (we && addr == ADDR_W'(W_TXP)),
        .wr_rxp_i   (we && addr == ADDR_W'(W_RXP)),
        .op_wdata_i (wr_data[2:0]),
        .tx_run_o   (tx_run_o),
        .rx_run_o   (rx_run_o),
        .flush_o    (tx_flush_o),
        .tx_poll_o  (tx_poll_o),
        .rx_poll_o  (rx_poll_o)
    );

    dma_csr_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (sw_clr),
        .evt_i    (evt_i),
        .w1c_i    (we && addr == ADDR_W'(W_STAT)),
        .wr_ien_i (we && addr == ADDR_W'(W_IEN)),
        .wdata_i  (wr_data[IEN_W-1:0]),
        .ev_o     (ev),
        .nsum_o   (nsum),
        .asum_o   (asum),
        .ien_o    (ien),
        .irq_o    (irq_o)
    );

    always_comb begin
        rd_data = '0;
        unique case (int'(addr))
            W_BUS:  rd_data[0] = soft_reset_o;
            W_STAT: begin
                rd_data[NUM_EVT-1:0]     = ev;
                rd_data[S_NSUM]          = nsum;
                rd_data[S_ASUM]          = asum;
                rd_data[S_RXST +: 3]     = rx_state_i;
                rd_data[S_TXST +: 3]     = tx_state_i;
            end
            W_OP: begin
                rd_data[OP_TXRUN] = tx_run_o;
                rd_data[OP_RXRUN] = rx_run_o;
                rd_data[OP_FLUSH] = tx_flush_o;
            end
            W_IEN:  rd_data[IEN_W-1:0] = ien;
            default: rd_data = '0;
        endcase
    end

    // R6: a poll pulse is always the echo of an accepted poll write
    p_txpoll_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_poll_o |-> $past(wr_en && !soft_reset_o && addr == ADDR_W'(W_TXP)));
    p_rxpoll_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_poll_o |-> $past(wr_en && !soft_reset_o && addr == ADDR_W'(W_RXP)));
    // R3: nothing runs while the software reset is in progress
    p_quiet_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset_o |-> !tx_run_o && !rx_run_o && !irq_o);
endmodule

// File: tb/dma_chan_csr_tb.sv
module dma_chan_csr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RST_CYC    = 8;
    localparam int FLUSH_CYC  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [11:0] evt_i = '0;
    logic [2:0]  tx_state_i = '0;
    logic [2:0]  rx_state_i = '0;
    logic tx_run_o, rx_run_o, tx_flush_o, soft_reset_o, tx_poll_o, rx_poll_o, irq_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_csr #(.ADDR_W(3), .RST_CYCLES(RST_CYC), .FLUSH_CYCLES(FLUSH_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .evt_i(evt_i), .tx_state_i(tx_state_i), .rx_state_i(rx_state_i),
        .tx_run_o(tx_run_o), .rx_run_o(rx_run_o), .tx_flush_o(tx_flush_o),
        .soft_reset_o(soft_reset_o), .tx_poll_o(tx_poll_o), .rx_poll_o(rx_poll_o),
        .irq_o(irq_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: act=%0d exp=<100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        addr = 3'(a); wr_data = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        addr = 3'(a); #1; d = rd_data;
    endtask

    task automatic pulse(input logic [11:0] e);
        evt_i = e;
        @(posedge clk); @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(a, d); check("R1 word read", d, 0);
        end
        check("R1 outputs", {25'b0, tx_run_o, rx_run_o, tx_flush_o, soft_reset_o,
              tx_poll_o, rx_poll_o, irq_o}, 0);
    endtask

    task automatic t_run();
        logic [31:0] d;
        wr(4, 32'h3);
        rd(4, d); check("R4 run readback", d, 3);
        check("R4 run outputs", {30'b0, tx_run_o, rx_run_o}, 2'b11);
        wr(4, 32'h2);
        check("R4 tx stop", {30'b0, tx_run_o, rx_run_o}, 2'b01);
        wr(4, 32'h0);
        rd(4, d); check("R4 both stop", d, 0);
    endtask

    task automatic t_poll();
        wr(1, 32'hDEAD_BEEF);
        check("R6 tx poll pulse", {30'b0, tx_poll_o, rx_poll_o}, 2'b10);
        @(posedge clk); @(negedge clk);
        check("R6 tx poll one cycle", {31'b0, tx_poll_o}, 0);
        wr(2, 32'h0);
        check("R6 rx poll pulse", {30'b0, tx_poll_o, rx_poll_o}, 2'b01);
        @(posedge clk); @(negedge clk);
        check("R6 rx poll one cycle", {31'b0, rx_poll_o}, 0);
    endtask

    task automatic t_events();
        logic [31:0] d;
        pulse(12'h020);
        rd(3, d); check("R7 event captured", d, 32'h20);
        wr(3, 32'h0);
        rd(3, d); check("R7 write zero keeps", d, 32'h20);
        pulse(12'h801);
        rd(3, d); check("R7 two more events", d, 32'h821);
        wr(3, 32'h020);
        rd(3, d); check("R7 w1c one bit", d, 32'h801);
        wr(3, 32'h801);
        rd(3, d); check("R7 w1c rest", d, 0);
        evt_i = 12'h040; addr = 3'd3; wr_data = 32'h040; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        evt_i = '0; wr_en = 1'b0; wr_data = '0;
        rd(3, d); check("R7 event beats clear", d, 32'h40);
        wr(3, 32'h040);
        rd(3, d); check("R7 collision bit cleared later", d, 0);
    endtask

    task automatic t_summary();
        logic [31:0] d;
        wr(5, 32'h2020);
        pulse(12'h020);
        rd(3, d); check("R8 abnormal summary", d, 32'h2020);
        check("R9 irq abnormal", {31'b0, irq_o}, 1);
        wr(3, 32'h2000);
        rd(3, d); check("R8 summary w1c", d, 32'h0020);
        check("R9 irq after summary clear", {31'b0, irq_o}, 0);
        pulse(12'h020);
        rd(3, d); check("R8 summary re-raised", d, 32'h2020);
        wr(3, 32'h0020);
        rd(3, d); check("R8 summary follows events", d, 0);
        check("R9 irq gone", {31'b0, irq_o}, 0);
        pulse(12'h008);
        rd(3, d); check("R8 unenabled event", d, 32'h0008);
        check("R9 no irq unenabled", {31'b0, irq_o}, 0);
        wr(3, 32'h0008);
        wr(5, 32'h0001);
        pulse(12'h001);
        rd(3, d); check("R8 normal summary", d, 32'h1001);
        check("R9 irq needs summary enable", {31'b0, irq_o}, 0);
        wr(5, 32'h1001);
        check("R9 irq normal", {31'b0, irq_o}, 1);
        wr(3, 32'h0001);
        rd(3, d); check("R8 normal cleared", d, 0);
        check("R9 irq normal cleared", {31'b0, irq_o}, 0);
        wr(5, 32'h0);
    endtask

    task automatic t_state();
        logic [31:0] d;
        tx_state_i = 3'd6; rx_state_i = 3'd4;
        rd(3, d); check("R10 state fields", d, 32'h0068_0000);
        tx_state_i = 3'd7; rx_state_i = 3'd0;
        rd(3, d); check("R10 state fields live", d, 32'h0070_0000);
        tx_state_i = 3'd0;
    endtask

    task automatic t_flush();
        logic [31:0] d;
        int n;
        wr(4, 32'h5);
        rd(4, d); check("R5 flush set", d, 32'h5);
        wr(4, 32'h1);
        rd(4, d); check("R5 write zero no cancel", d, 32'h5);
        n = 1;
        while (tx_flush_o && n < 1000) begin
            @(posedge clk); @(negedge clk); n++;
        end
        check("R5 flush length", n, FLUSH_CYC);
        rd(4, d); check("R5 flush cleared, run kept", d, 32'h1);
        wr(4, 32'h0);
    endtask

    task automatic t_softreset();
        logic [31:0] d;
        int n;
        wr(4, 32'h3);
        wr(5, 32'h2020);
        pulse(12'h020);
        check("R9 irq before reset", {31'b0, irq_o}, 1);
        wr(0, 32'h1);
        rd(0, d); check("R2 reset bit set", d, 1);
        check("R2 clears at once", {29'b0, tx_run_o, rx_run_o, irq_o}, 0);
        wr(4, 32'h3);
        pulse(12'h020);
        check("R3 write ignored", {30'b0, tx_run_o, rx_run_o}, 0);
        n = 2;
        while (soft_reset_o && n < 1000) begin
            @(posedge clk); @(negedge clk); n++;
        end
        check("R2 reset length", n, RST_CYC);
        rd(0, d); check("R2 reset bit dropped", d, 0);
        rd(4, d); check("R3 op stays clear", d, 0);
        rd(5, d); check("R2 ien cleared", d, 0);
        rd(3, d); check("R3 event during reset dropped", d, 0);
        wr(4, 32'h2);
        check("R4 writes work after reset", {30'b0, tx_run_o, rx_run_o}, 2'b01);
        wr(4, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_run();
        t_poll();
        t_events();
        t_summary();
        t_state();
        t_flush();
        t_softreset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule